// File: doc/BRIEF.md
# NAND Block Erase Sequencer

This block is the controller-side engine that erases one block of an 8-bit NAND flash device. The host raises a request together with a block address. The sequencer then selects the device and writes the erase-setup command. It follows with the block address bytes and then the erase-confirm command. Each byte goes out as a write strobe whose low and high widths are set in clock cycles.

Once the confirm command is out, the sequencer polls the device. It writes the read-status command and pulses read-enable once to take in the status byte. It repeats this until the device reports ready in the status byte. Completion is also accepted from the ready/busy pin. If the pin is high when a poll finishes, one more status poll is made and its result is final. Status bit 0 then tells pass from fail. A failure also raises a request to retire the block. If the device never finishes within a configurable number of cycles after confirm, a timeout result is reported. A timeout is kept separate from an erase failure.

The host sees a one-cycle acknowledge carrying exactly one of the pass, fail or timeout results. The next request is taken only after that acknowledge.

Top module: `nand_erase_seq`

## Requirements
- R1: While rst_ni is low, ack_o and every result output are low, chip-enable, write-enable and read-enable are high, CLE, ALE and the data output enable are low.
- R2: A request taken while idle produces this write sequence on the bus. First the command 0x60 with CLE high. Then ADDR_CYC address bytes with ALE high, least significant byte of blk_addr_i first. Then the command 0xD0 with CLE high. A byte counts as written at the rising edge of write-enable.
- R3: Each write-enable low pulse lasts exactly WE_LO_CYC clocks and is followed by at least WE_HI_CYC clocks high. CLE, ALE and the output byte stay constant while write-enable is low. CLE and ALE are never high together.
- R4: After the confirm command, each poll writes 0x70 with CLE high and then gives one read-enable low pulse of WE_LO_CYC clocks. The data output enable is low during that pulse. Polling repeats until a status byte has bit 6 set, and that poll is the last.
- R5: If nand_rb_i is high when a poll ends with status bit 6 clear, exactly one more poll is made. That poll's status decides the result whatever its bit 6.
- R6: At completion, status bit 0 equal to 0 gives pass_o with the acknowledge. Bit 0 equal to 1 gives fail_o and mark_bad_o with the acknowledge.
- R7: If TMO_CYC or more cycles have passed since the confirm command when a poll ends without completion, the result is timeout_o. It is reported with neither fail_o nor mark_bad_o.
- R8: ack_o is high for exactly one cycle per operation, with exactly one of pass_o, fail_o, timeout_o. All result outputs are low when ack_o is low.
- R9: req_i is ignored from acceptance until the acknowledge. A request pulse during an operation starts no second bus sequence.
- R10: Chip-enable is low from the cycle after a request is taken until the acknowledge cycle, in which it returns high. It stays high while idle, with no strobe active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Erase request, sampled while idle |
| blk_addr_i | input | BLK_W | Block address to erase |
| ack_o | output | 1 | One-cycle completion acknowledge |
| pass_o | output | 1 | Erase passed, valid with ack_o |
| fail_o | output | 1 | Erase failed, valid with ack_o |
| timeout_o | output | 1 | Device did not complete in time, valid with ack_o |
| mark_bad_o | output | 1 | Request to retire the block, valid with ack_o |
| status_o | output | 8 | Last status byte read, valid with ack_o |
| nand_ce_no | output | 1 | Chip enable, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write enable, active low |
| nand_re_no | output | 1 | Read enable, active low |
| nand_dq_o | output | 8 | Data bus, output half |
| nand_dq_oe_o | output | 1 | Data bus output enable |
| nand_dq_i | input | 8 | Data bus, input half |
| nand_rb_i | input | 1 | Ready/busy from the device, high when ready |

## Verification
A sequencer stuck in the wrong state shows up at the bus within one strobe period. A bad byte index or command selection shows as a wrong byte latched at the next write-enable rise. A bad strobe counter shows as a pulse of the wrong width on the same edge. Wrong completion or result logic shows at the acknowledge as a wrong result flag. It can also show as a wrong number of status polls, counted against the device model's ready point or the cycle where ready/busy rose. A fault in the idle or acknowledge handling appears as chip-enable out of step with the bench's own model of operation activity, in the very cycle it occurs.

// File: rtl/nand_erase_pkg.sv
package nand_erase_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CMD1,
    S_ADDR,
    S_CMD2,
    S_PCMD,
    S_PRD,
    S_DONE
  } seq_st_e;

  typedef enum logic [1:0] {
    P_IDLE,
    P_LO,
    P_HI
  } phy_st_e;

  localparam logic [7:0] CMD_ERASE   = 8'h60;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_STATUS  = 8'h70;

  localparam int ST_RDY_BIT  = 6;
  localparam int ST_FAIL_BIT = 0;

  typedef struct packed {
    logic       cle;
    logic       ale;
    logic       rd;
    logic [7:0] data;
  } bus_op_t;

endpackage

// File: rtl/nand_bus_phy.sv
// One bus cycle per start: strobe low LO_CYC clocks, high HI_CYC clocks.
module nand_bus_phy
  import nand_erase_pkg::*;
#(
  parameter int LO_CYC = 2,
  parameter int HI_CYC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  bus_op_t    op_i,
  output logic       done_o,
  output logic [7:0] rdata_o,
  output logic       cle_o,
  output logic       ale_o,
  output logic       we_no,
  output logic       re_no,
  output logic [7:0] dq_o,
  output logic       dq_oe_o,
  input  logic [7:0] dq_i
);

  localparam int MAX_CYC = (LO_CYC > HI_CYC) ? LO_CYC : HI_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  phy_st_e          st_q;
  bus_op_t          op_q;
  logic [CNT_W-1:0] cnt_q;
  logic             active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= P_IDLE;
      op_q    <= '0;
      cnt_q   <= '0;
      rdata_o <= '0;
    end else begin
      case (st_q)
        P_IDLE: if (start_i) begin
          op_q  <= op_i;
          cnt_q <= CNT_W'(LO_CYC - 1);
          st_q  <= P_LO;
        end
        P_LO: if (cnt_q == '0) begin
          if (op_q.rd) rdata_o <= dq_i;
          cnt_q <= CNT_W'(HI_CYC - 1);
          st_q  <= P_HI;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        P_HI: if (cnt_q == '0) begin
          st_q <= P_IDLE;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= P_IDLE;
      endcase
    end
  end

  assign active  = (st_q != P_IDLE);
  assign cle_o   = active && op_q.cle;
  assign ale_o   = active && op_q.ale;
  assign we_no   = !((st_q == P_LO) && !op_q.rd);
  assign re_no   = !((st_q == P_LO) && op_q.rd);
  assign dq_oe_o = active && !op_q.rd;
  assign dq_o    = dq_oe_o ? op_q.data : 8'h00;
  assign done_o  = (st_q == P_HI) && (cnt_q == '0);

endmodule

// File: rtl/nand_wait_timer.sv
module nand_wait_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic expired_o
);

  localparam int CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt_q;

  assign expired_o = (cnt_q >= CNT_W'(LIMIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (en_i && !expired_o) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/nand_erase_seq.sv
module nand_erase_seq
  import nand_erase_pkg::*;
#(
  parameter int BLK_W     = 16,
  parameter int ADDR_CYC  = 2,
  parameter int WE_LO_CYC = 2,
  parameter int WE_HI_CYC = 2,
  parameter int TMO_CYC   = 50000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [BLK_W-1:0] blk_addr_i,
  output logic             ack_o,
  output logic             pass_o,
  output logic             fail_o,
  output logic             timeout_o,
  output logic             mark_bad_o,
  output logic [7:0]       status_o,
  output logic             nand_ce_no,
  output logic             nand_cle_o,
  output logic             nand_ale_o,
  output logic             nand_we_no,
  output logic             nand_re_no,
  output logic [7:0]       nand_dq_o,
  output logic             nand_dq_oe_o,
  input  logic [7:0]       nand_dq_i,
  input  logic             nand_rb_i
);

  localparam int ADDR_BITS = 8 * ADDR_CYC;
  localparam int IDX_W     = (ADDR_CYC > 1) ? $clog2(ADDR_CYC) : 1;

  seq_st_e              st_q;
  logic                 launched_q;
  logic [ADDR_BITS-1:0] addr_q;
  logic [ADDR_BITS-1:0] blk_ext;
  logic [IDX_W-1:0]     idx_q;
  logic                 final_q;
  logic                 res_fail_q;
  logic                 res_tmo_q;
  logic [7:0]           stat_q;

  logic                 bus_st;
  logic                 phy_start;
  logic                 phy_done;
  logic [7:0]           phy_rdata;
  bus_op_t              phy_op;
  logic                 tmo_exp;

  generate
    if (BLK_W < ADDR_BITS) begin : g_zext
      assign blk_ext = {{(ADDR_BITS - BLK_W){1'b0}}, blk_addr_i};
    end else begin : g_trunc
      assign blk_ext = blk_addr_i[ADDR_BITS-1:0];
    end
  endgenerate

  assign bus_st    = (st_q inside {S_CMD1, S_ADDR, S_CMD2, S_PCMD, S_PRD});
  assign phy_start = bus_st && !launched_q;

  always_comb begin
    phy_op = '0;
    case (st_q)
      S_CMD1: begin phy_op.cle = 1'b1; phy_op.data = CMD_ERASE;   end
      S_ADDR: begin phy_op.ale = 1'b1; phy_op.data = addr_q[idx_q*8 +: 8]; end
      S_CMD2: begin phy_op.cle = 1'b1; phy_op.data = CMD_CONFIRM; end
      S_PCMD: begin phy_op.cle = 1'b1; phy_op.data = CMD_STATUS;  end
      S_PRD:  phy_op.rd = 1'b1;
      default: phy_op = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_IDLE;
      launched_q <= 1'b0;
      addr_q     <= '0;
      idx_q      <= '0;
      final_q    <= 1'b0;
      res_fail_q <= 1'b0;
      res_tmo_q  <= 1'b0;
      stat_q     <= '0;
    end else begin
      if (phy_done)       launched_q <= 1'b0;
      else if (phy_start) launched_q <= 1'b1;
      case (st_q)
        S_IDLE: if (req_i) begin
          addr_q  <= blk_ext;
          idx_q   <= '0;
          final_q <= 1'b0;
          st_q    <= S_CMD1;
        end
        S_CMD1: if (phy_done) st_q <= S_ADDR;
        S_ADDR: if (phy_done) begin
          if (idx_q == IDX_W'(ADDR_CYC - 1)) st_q <= S_CMD2;
          else idx_q <= idx_q + 1'b1;
        end
        S_CMD2: if (phy_done) st_q <= S_PCMD;
        S_PCMD: if (phy_done) st_q <= S_PRD;
        S_PRD: if (phy_done) begin
          stat_q <= phy_rdata;
          if (phy_rdata[ST_RDY_BIT] || final_q) begin
            res_fail_q <= phy_rdata[ST_FAIL_BIT];
            res_tmo_q  <= 1'b0;
            st_q       <= S_DONE;
          end else if (tmo_exp) begin
            res_fail_q <= 1'b0;
            res_tmo_q  <= 1'b1;
            st_q       <= S_DONE;
          end else begin
            // pin-reported ready: one confirming poll decides
            final_q <= nand_rb_i;
            st_q    <= S_PCMD;
          end
        end
        S_DONE:  st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  nand_bus_phy #(
    .LO_CYC(WE_LO_CYC),
    .HI_CYC(WE_HI_CYC)
  ) phy_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(phy_start),
    .op_i   (phy_op),
    .done_o (phy_done),
    .rdata_o(phy_rdata),
    .cle_o  (nand_cle_o),
    .ale_o  (nand_ale_o),
    .we_no  (nand_we_no),
    .re_no  (nand_re_no),
    .dq_o   (nand_dq_o),
    .dq_oe_o(nand_dq_oe_o),
    .dq_i   (nand_dq_i)
  );

  nand_wait_timer #(
    .LIMIT(TMO_CYC)
  ) tmr_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (st_q == S_IDLE),
    .en_i     ((st_q == S_PCMD) || (st_q == S_PRD)),
    .expired_o(tmo_exp)
  );

  assign ack_o      = (st_q == S_DONE);
  assign pass_o     = ack_o && !res_fail_q && !res_tmo_q;
  assign fail_o     = ack_o && res_fail_q;
  assign timeout_o  = ack_o && res_tmo_q;
  assign mark_bad_o = ack_o && res_fail_q;
  assign status_o   = ack_o ? stat_q : 8'h00;
  assign nand_ce_no = (st_q == S_IDLE) || (st_q == S_DONE);

endmodule

// File: rtl/nand_erase_seq_chk.sv
module nand_erase_seq_chk #(
  parameter int WE_LO_CYC = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ack_o,
  input logic       pass_o,
  input logic       fail_o,
  input logic       timeout_o,
  input logic       mark_bad_o,
  input logic       nand_ce_no,
  input logic       nand_cle_o,
  input logic       nand_ale_o,
  input logic       nand_we_no,
  input logic       nand_re_no,
  input logic [7:0] nand_dq_o,
  input logic       nand_dq_oe_o
);

  logic [15:0] lo_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         lo_run_q <= '0;
    else if (!nand_we_no) lo_run_q <= lo_run_q + 1'b1;
    else                 lo_run_q <= '0;
  end

  AST_ACK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);  // R8
  AST_ONE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> ($countones({pass_o, fail_o, timeout_o}) == 1));  // R8
  AST_MARK_ON_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mark_bad_o |-> (fail_o && !timeout_o));  // R6
  AST_CLE_ALE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nand_cle_o && nand_ale_o));  // R3
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!nand_we_no && !nand_re_no));  // R3
  AST_STROBE_SELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nand_we_no || !nand_re_no) |-> !nand_ce_no);  // R10
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nand_ce_no |-> (nand_we_no && nand_re_no && !nand_dq_oe_o));  // R10
  AST_READ_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nand_re_no |-> !nand_dq_oe_o);  // R4
  AST_WE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nand_we_no && $past(!nand_we_no)) |->
      ($stable(nand_dq_o) && $stable(nand_cle_o) && $stable(nand_ale_o)));  // R3
  AST_WE_LOW_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nand_we_no) |-> (lo_run_q == 16'(WE_LO_CYC)));  // R3

endmodule

bind nand_erase_seq nand_erase_seq_chk #(
  .WE_LO_CYC(WE_LO_CYC)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ack_o       (ack_o),
  .pass_o      (pass_o),
  .fail_o      (fail_o),
  .timeout_o   (timeout_o),
  .mark_bad_o  (mark_bad_o),
  .nand_ce_no  (nand_ce_no),
  .nand_cle_o  (nand_cle_o),
  .nand_ale_o  (nand_ale_o),
  .nand_we_no  (nand_we_no),
  .nand_re_no  (nand_re_no),
  .nand_dq_o   (nand_dq_o),
  .nand_dq_oe_o(nand_dq_oe_o)
);

// File: tb/nand_erase_seq_tb_top.sv
module nand_erase_seq_tb_top;

  localparam int BLK_W = 16;
  localparam int ACYC  = 2;
  localparam int LO    = 2;
  localparam int HI    = 2;
  localparam int TMO   = 400;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic             req_i = 1'b0;
  logic [BLK_W-1:0] blk_addr_i = '0;
  logic             ack_o, pass_o, fail_o, timeout_o, mark_bad_o;
  logic [7:0]       status_o;
  logic             ce_n, cle, ale, we_n, re_n, dq_oe;
  logic [7:0]       dq_o;
  logic [7:0]       dq_drv = 8'h00;
  logic             rb_force = 1'b0;

  nand_erase_seq #(
    .BLK_W(BLK_W), .ADDR_CYC(ACYC), .WE_LO_CYC(LO), .WE_HI_CYC(HI), .TMO_CYC(TMO)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .blk_addr_i(blk_addr_i),
    .ack_o(ack_o), .pass_o(pass_o), .fail_o(fail_o), .timeout_o(timeout_o),
    .mark_bad_o(mark_bad_o), .status_o(status_o),
    .nand_ce_no(ce_n), .nand_cle_o(cle), .nand_ale_o(ale), .nand_we_no(we_n),
    .nand_re_no(re_n), .nand_dq_o(dq_o), .nand_dq_oe_o(dq_oe),
    .nand_dq_i(dq_drv), .nand_rb_i(rb_force)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // device model and bus recorder
  int        busy_left = 0, scen_busy = 0, rb_k = 0, rd_cnt = 0, d0_cyc = 0;
  bit        stuck = 0, fbit = 0, m_active = 0;
  bit        prev_we = 1, prev_re = 1;
  int        lo_run = 0, hi_run = 1000;
  logic [7:0] last_st = 8'h00;
  logic [7:0] lat_b[$];
  bit         lat_a[$];
  logic [7:0] rd_q[$];

  always @(negedge clk) begin
    cyc++;
    if (rst_ni) begin
      chk(ce_n == (!m_active || ack_o), "R10", "chip enable vs activity", ce_n, !m_active || ack_o);
      chk(!(cle && ale), "R3", "cle and ale together", {cle, ale}, 0);
      chk(!(!re_n && dq_oe), "R4", "driving during read", dq_oe, 0);
      chk(ack_o || !(pass_o || fail_o || timeout_o || mark_bad_o), "R8", "result without ack",
          {pass_o, fail_o, timeout_o, mark_bad_o}, 0);
      if (!we_n) lo_run++; else hi_run++;
      if (prev_we && !we_n) begin
        chk(hi_run >= HI, "R3", "write-enable high width", hi_run, HI);
        lo_run = 1;
      end
      if (!prev_we && we_n) begin
        chk(lo_run == LO, "R3", "write-enable low width", lo_run, LO);
        chk(cle ^ ale, "R3", "latch kind", {cle, ale}, 1);
        lat_b.push_back(dq_o);
        lat_a.push_back(ale);
        if (cle && dq_o == 8'hD0) begin
          busy_left = scen_busy;
          d0_cyc = cyc;
        end
        hi_run = 1;
      end
      if (busy_left > 0) busy_left--;
      dq_drv = {1'b0, (busy_left == 0) && !stuck, 5'b0, fbit};
      if (!re_n) begin
        last_st = dq_drv;
        if (prev_re) begin
          rd_cnt++;
          if (rb_k > 0 && rd_cnt == rb_k) rb_force = 1'b1;
        end
      end
      if (!prev_re && re_n) rd_q.push_back(last_st);
      m_active = m_active ? !ack_o : req_i;
      prev_we = we_n;
      prev_re = re_n;
    end
  end

  task automatic run_op(input logic [15:0] addr, input int busy, input bit fb, input bit stk,
                        input int rbk, input bit poke, input int exp_res, input int exp_reads);
    bit got = 0;
    int n = 0, ack_cyc = 0, polls, nb;
    bit r_pass = 0, r_fail = 0, r_tmo = 0, r_mark = 0;
    lat_b.delete(); lat_a.delete(); rd_q.delete();
    scen_busy = busy; fbit = fb; stuck = stk; rb_k = rbk; rb_force = 1'b0; rd_cnt = 0;
    @(posedge clk); #1;
    blk_addr_i = addr; req_i = 1'b1;
    @(posedge clk); #1;
    req_i = 1'b0;
    while (!got && n < 20000) begin
      @(negedge clk);
      n++;
      if (poke && n == 12) begin req_i = 1'b1; blk_addr_i = ~addr; end
      if (poke && n == 13) req_i = 1'b0;
      if (ack_o) begin
        got = 1; ack_cyc = cyc;
        r_pass = pass_o; r_fail = fail_o; r_tmo = timeout_o; r_mark = mark_bad_o;
      end
    end
    chk(got, "R8", "ack arrived", got, 1);
    @(negedge clk);
    chk(!ack_o, "R8", "ack single cycle", ack_o, 0);
    chk(r_pass == (exp_res == 0), "R6", "pass", r_pass, exp_res == 0);
    chk(r_fail == (exp_res == 1), "R6", "fail", r_fail, exp_res == 1);
    chk(r_mark == (exp_res == 1), "R6", "mark bad", r_mark, exp_res == 1);
    chk(r_tmo == (exp_res == 2), "R7", "timeout", r_tmo, exp_res == 2);
    nb = lat_b.size();
    chk(nb >= ACYC + 3, "R2", "bytes written", nb, ACYC + 3);
    if (nb >= ACYC + 3) begin
      chk(lat_b[0] == 8'h60 && !lat_a[0], "R2", "setup command", lat_b[0], 8'h60);
      for (int i = 0; i < ACYC; i++)
        chk(lat_b[1+i] == addr[8*i +: 8] && lat_a[1+i], "R2", "address byte",
            lat_b[1+i], addr[8*i +: 8]);
      chk(lat_b[1+ACYC] == 8'hD0 && !lat_a[1+ACYC], "R2", "confirm command",
          lat_b[1+ACYC], 8'hD0);
      polls = nb - (ACYC + 2);
      for (int i = ACYC + 2; i < nb; i++)
        chk(lat_b[i] == 8'h70 && !lat_a[i], "R4", "status command", lat_b[i], 8'h70);
      chk(rd_q.size() == polls, "R4", "one read per status command", rd_q.size(), polls);
    end
    if (!stk && rd_q.size() > 0) begin
      for (int i = 0; i < rd_q.size() - 1; i++)
        chk(!rd_q[i][6], "R4", "early poll not ready", rd_q[i], 0);
      chk(rd_q[rd_q.size()-1][6], "R4", "last poll ready", rd_q[rd_q.size()-1], 8'h40);
    end
    if (exp_reads >= 0)
      chk(rd_q.size() == exp_reads, "R5", "poll count", rd_q.size(), exp_reads);
    if (exp_res == 2)
      chk(ack_cyc - d0_cyc >= TMO, "R7", "wait before timeout", ack_cyc - d0_cyc, TMO);
    for (int i = 0; i < 20; i++) @(negedge clk);
    chk(lat_b.size() == nb && ce_n, "R9", "no second operation", lat_b.size(), nb);
  endtask

  initial begin
    wait (cyc >= 150000);
    n_bad++;
    $display("FAIL R8 watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) @(negedge clk);
    chk(!ack_o && !pass_o && !fail_o && !timeout_o && !mark_bad_o, "R1", "results in reset",
        {ack_o, pass_o, fail_o, timeout_o, mark_bad_o}, 0);
    chk(ce_n && we_n && re_n, "R1", "strobes in reset", {ce_n, we_n, re_n}, 7);
    chk(!cle && !ale && !dq_oe, "R1", "latches in reset", {cle, ale, dq_oe}, 0);
    @(posedge clk); #1;
    rst_ni = 1'b1;
    // normal pass, rb held low so only status bit 6 ends polling
    run_op(16'h1234, 30, 1'b0, 1'b0, 0, 1'b0, 0, -1);
    // normal fail
    run_op(16'hA5C3, 25, 1'b1, 1'b0, 0, 1'b0, 1, -1);
    // ready at once: single poll
    run_op(16'h00FF, 0, 1'b0, 1'b0, 0, 1'b0, 0, 1);
    // status never ready, pin rises during third read: R5 expects four polls
    run_op(16'h8001, 0, 1'b0, 1'b1, 3, 1'b0, 0, 4);
    // pin path with failing status
    run_op(16'h4002, 0, 1'b1, 1'b1, 2, 1'b0, 1, 3);
    // timeout, fail bit set but must not be reported as fail
    run_op(16'h7E7E, 0, 1'b1, 1'b1, 0, 1'b0, 2, -1);
    // request pulse during a running operation is ignored (R9)
    run_op(16'h5AA5, 40, 1'b0, 1'b0, 0, 1'b1, 0, -1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule